// File: doc/BRIEF.md
# Bulk Endpoint Transfer Packetizer

This block manages a single bulk or interrupt device endpoint. Software (or a descriptor engine) loads a transfer descriptor holding a total byte count, the endpoint's maximum packet size, a zero-length-termination control bit and a two-bit high-bandwidth multiplier field. A good load primes the endpoint. The block then breaks the transfer into a sequence of packet lengths and answers each host token on the endpoint with the length of the packet due next. Tokens of either direction (IN or OUT) share one port and are treated identically, because bulk and interrupt endpoints behave the same way.

Each token arrives with an outcome bit: high when the host acknowledged the packet (IN) or when the device accepted it (OUT). Only a successful attempt consumes the packet and lowers the remaining byte count. When the final packet succeeds, the descriptor is retired. A one-cycle done strobe marks retirement, the remaining count is then zero, and the endpoint drops back to the unprimed state, in which every token gets NAK.

Responses are registered. A token sampled at a clock edge is answered by the outputs that this same edge updates.

Top module: `bulk_pkt_ep`

## Requirements
- R1: While the endpoint is unprimed, every token is answered with hs_nak_o=1 and pkt_len_o=0. A token in the same cycle as a descriptor load is also answered with NAK.
- R2: Once a good descriptor has been loaded, the next token is answered with hs_valid_o=1, hs_nak_o=0 and the length of the packet due.
- R3: Every packet except the last carries the maximum packet size, and the last carries what remains. For example, 511 bytes at size 256 give 256 then 255.
- R4: With zero-length termination off (zlt=0), a transfer has floor(bytes/size)+1 packets. A transfer that is an exact multiple of the size therefore ends with a 0-byte packet: 512 at 256 gives 256, 256, 0, and 512 at 512 gives 512, 0.
- R5: With zero-length termination on (zlt=1), a transfer has ceil(bytes/size) packets and no trailing 0-byte packet: 512 at 512 gives a single 512.
- R6: A descriptor of 0 bytes gives exactly one 0-byte packet, whatever the zlt setting.
- R7: A token with tok_ok_i=0 on a primed endpoint is answered with the same packet length as the previous attempt, and remain_o does not change.
- R8: remain_o shows the bytes still to move. A successful packet lowers it by that packet's length.
- R9: When the last packet succeeds, done_o is high for exactly one cycle, in the same cycle as that packet's response, and remain_o is 0. Later tokens are answered with NAK until the next load.
- R10: A load whose multiplier field is nonzero, or whose packet size is 0, sets cfg_err_o and leaves the endpoint unprimed. The next good load clears cfg_err_o.
- R11: A load while a transfer is in progress replaces the descriptor. Packets then follow the new byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_load_i | input | 1 | Load the descriptor fields and prime the endpoint |
| desc_bytes_i | input | BYTES_W | Total byte count of the transfer |
| desc_mps_i | input | MPS_W | Maximum packet size |
| desc_zlt_i | input | 1 | 1 = no trailing zero-length packet |
| desc_mult_i | input | 2 | High-bandwidth multiplier field; must be 0 |
| tok_valid_i | input | 1 | Host token (IN or OUT) addressed to the endpoint |
| tok_ok_i | input | 1 | Attempt outcome: 1 = host ACK (IN) or data accepted (OUT) |
| hs_valid_o | output | 1 | Response to the token sampled at the last edge |
| hs_nak_o | output | 1 | 1 = NAK, 0 = packet served |
| pkt_len_o | output | MPS_W | Length of the packet served (0 with NAK) |
| done_o | output | 1 | One-cycle strobe: descriptor retired |
| remain_o | output | BYTES_W | Bytes still to transfer |
| cfg_err_o | output | 1 | Last load was rejected |

## Verification
The table cases separate the two termination rules. These are 511 and 512 bytes at sizes 256 and 512, with zlt both off and on. Exact multiples expose a wrong or missing trailing zero-length packet, and the 511-byte remainder exposes a wrong last-packet length. Zero-byte descriptors in both modes check the single-packet corner. Runs with failed attempts mixed in separate a repeated packet from a consumed one. Bad loads, tokens before priming and tokens after retirement check that NAK replaces data at the right times. A long random mix of loads, tokens and outcomes, compared on every clock against a queue-based model, catches ordering faults such as a load colliding with a token.

// File: rtl/ep_pkt_pkg.sv
package ep_pkt_pkg;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_TOKEN = 2'd2
  } ep_ev_e;

  // load wins over a coincident token
  function automatic ep_ev_e decode_ev(input logic load, input logic tok);
    if (load)     return EV_LOAD;
    else if (tok) return EV_TOKEN;
    else          return EV_IDLE;
  endfunction

endpackage

// File: rtl/ep_desc_check.sv
module ep_desc_check #(
  parameter int unsigned MPS_W  = 11,
  parameter int unsigned MULT_W = 2
) (
  input  logic [MPS_W-1:0]  mps_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              good_o
);
  always_comb good_o = (mult_i == '0) && (mps_i != '0);
endmodule

// File: rtl/ep_pkt_calc.sv
module ep_pkt_calc #(
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned MPS_W   = 11
) (
  input  logic [BYTES_W-1:0] remain_i,
  input  logic [MPS_W-1:0]   mps_i,
  input  logic               zlt_i,
  output logic [MPS_W-1:0]   len_o,
  output logic               last_o
);
  logic [BYTES_W-1:0] mps_ext;
  logic               above, equal;

  always_comb begin
    mps_ext = BYTES_W'(mps_i);
    above   = remain_i > mps_ext;
    equal   = remain_i == mps_ext;
    len_o   = (above || equal) ? mps_i : remain_i[MPS_W-1:0];
    // an exactly full packet is last only when termination is suppressed
    last_o  = !above && !(equal && !zlt_i);
  end
endmodule

// File: rtl/ep_xfer_state.sv
module ep_xfer_state
  import ep_pkt_pkg::*;
#(
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned MPS_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ep_ev_e             ev_i,
  input  logic               accept_i,
  input  logic               tok_ok_i,
  input  logic [BYTES_W-1:0] ld_bytes_i,
  input  logic [MPS_W-1:0]   ld_mps_i,
  input  logic               ld_zlt_i,
  input  logic               ld_good_i,
  input  logic [MPS_W-1:0]   step_len_i,
  input  logic               step_last_i,
  output logic               primed_o,
  output logic [BYTES_W-1:0] remain_o,
  output logic [MPS_W-1:0]   mps_o,
  output logic               zlt_o,
  output logic               cfg_err_o
);
  logic               primed_q, zlt_q, err_q;
  logic [BYTES_W-1:0] remain_q;
  logic [MPS_W-1:0]   mps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      zlt_q    <= 1'b0;
      err_q    <= 1'b0;
      remain_q <= '0;
      mps_q    <= '0;
    end else if (ev_i == EV_LOAD) begin
      err_q <= !ld_good_i;
      if (ld_good_i) begin
        primed_q <= 1'b1;
        remain_q <= ld_bytes_i;
        mps_q    <= ld_mps_i;
        zlt_q    <= ld_zlt_i;
      end else begin
        primed_q <= 1'b0;
        remain_q <= '0;
      end
    end else if (accept_i) begin
      remain_q <= remain_q - BYTES_W'(step_len_i);
      if (step_last_i) primed_q <= 1'b0;
    end
  end

  assign primed_o  = primed_q;
  assign remain_o  = remain_q;
  assign mps_o     = mps_q;
  assign zlt_o     = zlt_q;
  assign cfg_err_o = err_q;

  // R7
  a_r7_fail_keeps_remain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_TOKEN && !tok_ok_i) |=> $stable(remain_q));
  // R1
  a_r1_stays_unprimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!primed_q && ev_i != EV_LOAD) |=> !primed_q);
  // R9
  a_r9_last_unprimes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && step_last_i && ev_i == EV_TOKEN) |=> (!primed_q && remain_q == '0));
  // R10
  a_r10_bad_load_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_LOAD && !ld_good_i) |=> (err_q && !primed_q));
endmodule

// File: rtl/bulk_pkt_ep.sv
module bulk_pkt_ep
  import ep_pkt_pkg::*;
#(
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned MPS_W   = 11,
  parameter int unsigned MULT_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_load_i,
  input  logic [BYTES_W-1:0] desc_bytes_i,
  input  logic [MPS_W-1:0]   desc_mps_i,
  input  logic               desc_zlt_i,
  input  logic [MULT_W-1:0]  desc_mult_i,
  input  logic               tok_valid_i,
  input  logic               tok_ok_i,
  output logic               hs_valid_o,
  output logic               hs_nak_o,
  output logic [MPS_W-1:0]   pkt_len_o,
  output logic               done_o,
  output logic [BYTES_W-1:0] remain_o,
  output logic               cfg_err_o
);
  ep_ev_e             ev;
  logic               ld_good, primed, zlt, serve, accept, step_last;
  logic [BYTES_W-1:0] remain;
  logic [MPS_W-1:0]   mps, step_len;

  assign ev     = decode_ev(desc_load_i, tok_valid_i);
  assign serve  = (ev == EV_TOKEN) && primed;
  assign accept = serve && tok_ok_i;

  ep_desc_check #(.MPS_W(MPS_W), .MULT_W(MULT_W)) u_check (
    .mps_i  (desc_mps_i),
    .mult_i (desc_mult_i),
    .good_o (ld_good)
  );

  ep_pkt_calc #(.BYTES_W(BYTES_W), .MPS_W(MPS_W)) u_calc (
    .remain_i (remain),
    .mps_i    (mps),
    .zlt_i    (zlt),
    .len_o    (step_len),
    .last_o   (step_last)
  );

  ep_xfer_state #(.BYTES_W(BYTES_W), .MPS_W(MPS_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .accept_i    (accept),
    .tok_ok_i    (tok_ok_i),
    .ld_bytes_i  (desc_bytes_i),
    .ld_mps_i    (desc_mps_i),
    .ld_zlt_i    (desc_zlt_i),
    .ld_good_i   (ld_good),
    .step_len_i  (step_len),
    .step_last_i (step_last),
    .primed_o    (primed),
    .remain_o    (remain),
    .mps_o       (mps),
    .zlt_o       (zlt),
    .cfg_err_o   (cfg_err_o)
  );

  logic             hs_valid_q, hs_nak_q, done_q;
  logic [MPS_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_q <= 1'b0;
      hs_nak_q   <= 1'b0;
      len_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      hs_valid_q <= tok_valid_i;
      hs_nak_q   <= tok_valid_i && !serve;
      len_q      <= serve ? step_len : '0;
      done_q     <= accept && step_last;
    end
  end

  assign hs_valid_o = hs_valid_q;
  assign hs_nak_o   = hs_nak_q;
  assign pkt_len_o  = len_q;
  assign done_o     = done_q;
  assign remain_o   = remain;

  // R1
  a_r1_nak_unprimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && (!primed || desc_load_i)) |=> (hs_nak_o && pkt_len_o == '0));
  // R3
  a_r3_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && !hs_nak_o) |-> (pkt_len_o <= mps));
  // R9
  a_r9_done_remain_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (remain_o == '0 && hs_valid_o && !hs_nak_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  a_r8_remain_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !desc_load_i) |=> (remain_o == $past(remain) - BYTES_W'(pkt_len_o)));
endmodule

// File: tb/bulk_pkt_ep_test.sv
module bulk_pkt_ep_test;
  localparam int CLK_P = 10;
  localparam int BW = 16;
  localparam int MW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 0, zlt = 0, tv = 0, tok = 0;
  logic [BW-1:0] bytes = '0;
  logic [MW-1:0] mps = '0;
  logic [1:0] mult = '0;
  logic hs_valid, hs_nak, done, cfg_err;
  logic [MW-1:0] plen;
  logic [BW-1:0] remain;

  always #(CLK_P/2) clk = ~clk;

  bulk_pkt_ep #(.BYTES_W(BW), .MPS_W(MW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_load_i(ld), .desc_bytes_i(bytes), .desc_mps_i(mps),
    .desc_zlt_i(zlt), .desc_mult_i(mult),
    .tok_valid_i(tv), .tok_ok_i(tok),
    .hs_valid_o(hs_valid), .hs_nak_o(hs_nak), .pkt_len_o(plen),
    .done_o(done), .remain_o(remain), .cfg_err_o(cfg_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model
  int q[$];
  bit m_primed = 0, m_err = 0;
  int m_remain = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void build(int b, int m, bit z);
    int n;
    q.delete();
    if (z) n = (b + m - 1) / m;
    else   n = b / m + 1;
    if (n == 0) n = 1;
    for (int i = 0; i < n - 1; i++) q.push_back(m);
    q.push_back(b - (n - 1) * m);
  endfunction

  task automatic step(bit l, int b, int m, bit z, int mu, bit t, bit ok, string tag);
    bit e_nak, e_done;
    int e_len;
    @(negedge clk);
    ld = l; bytes = BW'(b); mps = MW'(m); zlt = z; mult = 2'(mu); tv = t; tok = ok;
    e_nak = t && (l || !m_primed);
    e_len = (t && !l && m_primed) ? q[0] : 0;
    e_done = 0;
    if (l) begin
      m_err = !(mu == 0 && m != 0);
      if (!m_err) begin
        build(b, m, z);
        m_primed = 1; m_remain = b;
      end else begin
        m_primed = 0; m_remain = 0;
      end
    end else if (t && m_primed && ok) begin
      m_remain -= q[0];
      void'(q.pop_front());
      if (q.size() == 0) begin
        m_primed = 0; e_done = 1;
      end
    end
    @(posedge clk); #1;
    chk(tag, "hs_valid", int'(hs_valid), int'(t));
    chk(tag, "hs_nak", int'(hs_nak), int'(e_nak));
    chk(tag, "pkt_len", int'(plen), e_len);
    chk(tag, "done", int'(done), int'(e_done));
    chk(tag, "remain", int'(remain), m_remain);
    chk(tag, "cfg_err", int'(cfg_err), int'(m_err));
    @(negedge clk);
    ld = 0; tv = 0; tok = 0;
  endtask

  task automatic run_xfer(int b, int m, bit z, int exp[$], string tag);
    int got[$];
    step(1, b, m, z, 0, 0, 0, tag);
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 0, 0, 1, 1, tag);
      got.push_back(int'(plen));
      if (done) break;
    end
    chk(tag, "packet_count", got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      chk(tag, "packet_len", got[i], exp[i]);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset_hs_valid", int'(hs_valid), 0);
    chk("R8", "reset_remain", int'(remain), 0);
    chk("R9", "reset_done", int'(done), 0);
    chk("R10", "reset_cfg_err", int'(cfg_err), 0);
    @(negedge clk); rst_n = 1;

    // R1: tokens before priming
    step(0, 0, 0, 0, 0, 1, 1, "R1");
    step(0, 0, 0, 0, 0, 1, 0, "R1");
    // R2, R3
    run_xfer(511, 256, 0, '{256, 255}, "R3");
    // R4
    run_xfer(512, 256, 0, '{256, 256, 0}, "R4");
    run_xfer(512, 512, 0, '{512, 0}, "R4");
    // R5
    run_xfer(512, 512, 1, '{512}, "R5");
    run_xfer(512, 256, 1, '{256, 256}, "R5");
    run_xfer(511, 256, 1, '{256, 255}, "R5");
    // R6
    run_xfer(0, 64, 0, '{0}, "R6");
    run_xfer(0, 64, 1, '{0}, "R6");
    // R9: NAK after retirement
    step(0, 0, 0, 0, 0, 1, 1, "R9");
    // R7, R8: failed attempts mixed in
    step(1, 600, 256, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    // R11: reload mid-transfer, load with coincident token NAKed
    step(1, 100, 64, 1, 0, 1, 1, "R11");
    step(0, 0, 0, 0, 0, 1, 1, "R11");
    step(0, 0, 0, 0, 0, 1, 1, "R11");
    step(0, 0, 0, 0, 0, 1, 1, "R9");
    // R10
    step(1, 300, 64, 0, 2, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    step(1, 300, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    step(1, 300, 64, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R2");

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 4)
        step(1, int'($urandom_range(0, 2000)), int'($urandom_range(1, 600)),
             1'($urandom_range(0, 1)), (r == 0) ? 1 : 0, 1'($urandom_range(0, 1)), 1'b1, "R11");
      else if (r < 80)
        step(0, 0, 0, 0, 0, 1, (r < 65), "R8");
      else
        step(0, 0, 0, 0, 0, 0, 0, "R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule